// File: doc/BRIEF.md
# Tiled depth buffer address generator

This block turns a pixel coordinate into a byte offset inside a depth surface. The caller supplies the pixel's x and y, a window origin that is added to both before any other arithmetic, and the surface pitch in pixels. Two select inputs pick the pixel size (2 bytes or 4 bytes) and the layout. The linear layout is plain row-major. The tiled layout interleaves low x and y bits with tile index bits and XORs some of them together, so that neighbouring rows fall into different banks.

Each accepted request produces one registered offset a clock later, under a valid/ready pair. A parameter picks the alternative 4-byte tile geometry, which uses 16-pixel steps instead of 8-pixel steps. Any pitch that is not a multiple of 32 pixels is flagged beside the result. In that case the offset is still computed, but its value has no defined meaning.

Top module: `zaddr_gen`

## Requirements
- R1: With linear layout (`tiled`=0) and 4-byte pixels (`z16`=0), `addr` equals 4*(X + Y*pitch). X = `px`+`org_x` and Y = `py`+`org_y`.
- R2: With linear layout and 2-byte pixels (`z16`=1), `addr` equals 2*(X + Y*pitch).
- R3: With tiled layout and 4-byte pixels, T = (Y/8)*(pitch/8) + X/8 (16 in place of 8 when ALT_TILE=1). The address bits are: [1:0]=0, [4:2]=X[2:0], [6:5]=Y[1:0], [7]=X[4]^Y[2], [9:8]=T[1:0], [10]=Y[3], [11]=X[3]^Y[4], [31:12]=T>>2.
- R4: With tiled layout and 2-byte pixels, T = (Y/16)*(pitch/32) + X/32. The address bits are: [0]=0, [3:1]=X[2:0], [6:4]=Y[2:0], [7]=X[3], [9:8]=T[1:0], [10]=Y[3], [11]=X[4]^Y[4], [31:12]=T>>2.
- R5: The origin inputs are added to the coordinates before every address formula is applied.
- R6: A request accepted on a clock edge (`in_valid` and `in_ready` both high) shows up with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `addr` and `pitch_err` hold their values.
- R8: `pitch_err` is 1 alongside a result whose request had pitch mod 32 != 0, and 0 otherwise.
- R9: Every result is aligned to the pixel size: bit 0 is always 0, and bit 1 is also 0 for 4-byte pixels.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| px | input | COORD_W | Pixel x |
| py | input | COORD_W | Pixel y |
| org_x | input | COORD_W | Window origin x |
| org_y | input | COORD_W | Window origin y |
| pitch | input | PITCH_W | Surface pitch in pixels |
| z16 | input | 1 | 1: 2-byte pixels, 0: 4-byte pixels |
| tiled | input | 1 | 1: tiled layout, 0: linear |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| addr | output | ADDR_W | Byte offset |
| pitch_err | output | 1 | Pitch of this result not a multiple of 32 |

## Verification
The assertions assume that inputs do not change during the edge at which they are sampled, and that the consumer only drops `out_ready` through the normal handshake. The bench changes inputs only on falling edges, which keeps them within that assumption. The offset formulas are checked only for pitches that are multiples of 32, because other pitches raise the error flag and carry no defined offset. The sweep therefore uses pitches of 32, 64 and 96, with coordinate sums kept small enough that no width overflows. Two odd pitches are used only to exercise the error flag.

// File: rtl/zaddr_gen.sv
module zaddr_gen #(
  parameter int COORD_W  = 12,
  parameter int PITCH_W  = 12,
  parameter int ADDR_W   = 32,
  parameter bit ALT_TILE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic [PITCH_W-1:0] pitch,
  input  logic               z16,
  input  logic               tiled,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  addr,
  output logic               pitch_err
);
  localparam int TSH = ALT_TILE ? 4 : 3;

  logic [ADDR_W-1:0] ex, ey, ep;
  logic [ADDR_W-1:0] lin, t32, t16, a32, a16, addr_d;
  logic              take, z16_q;

  assign ex = ADDR_W'(px) + ADDR_W'(org_x);
  assign ey = ADDR_W'(py) + ADDR_W'(org_y);
  assign ep = ADDR_W'(pitch);

  assign lin = ex + ey * ep;

  assign t32 = (ey >> TSH) * (ep >> TSH) + (ex >> TSH);
  assign t16 = (ey >> 4) * (ep >> 5) + (ex >> 5);

  assign a32 = ((t32 >> 2) << 12)
             | (ADDR_W'(ex[3] ^ ey[4]) << 11)
             | (ADDR_W'(ey[3]) << 10)
             | (ADDR_W'(t32[1:0]) << 8)
             | (ADDR_W'(ex[4] ^ ey[2]) << 7)
             | (ADDR_W'(ey[1:0]) << 5)
             | (ADDR_W'(ex[2:0]) << 2);

  assign a16 = ((t16 >> 2) << 12)
             | (ADDR_W'(ex[4] ^ ey[4]) << 11)
             | (ADDR_W'(ey[3]) << 10)
             | (ADDR_W'(t16[1:0]) << 8)
             | (ADDR_W'(ex[3]) << 7)
             | (ADDR_W'(ey[2:0]) << 4)
             | (ADDR_W'(ex[2:0]) << 1);

  always_comb begin
    if (tiled) addr_d = z16 ? a16 : a32;
    else       addr_d = z16 ? (lin << 1) : (lin << 2);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      pitch_err <= 1'b0;
      z16_q     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      addr      <= addr_d;
      pitch_err <= |pitch[4:0];
      z16_q     <= z16;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(addr) && $stable(pitch_err));

  assert_pitch_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (pitch % 32 != 0) |=> pitch_err);

  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !addr[0] && (z16_q || !addr[1]));
endmodule

// File: tb/zaddr_gen_test.sv
module zaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] px = '0, py = '0, org_x = '0, org_y = '0, pitch = 12'd64;
  logic        z16 = 1'b0, tiled = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] addr;
  logic        pitch_err;
  int          checks = 0, fails = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  zaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .px(px), .py(py), .org_x(org_x), .org_y(org_y), .pitch(pitch),
    .z16(z16), .tiled(tiled), .out_valid(out_valid), .out_ready(out_ready),
    .addr(addr), .pitch_err(pitch_err)
  );

  function automatic int unsigned expect_addr(int x, int y, int p, bit h, bit t);
    int unsigned ba;
    if (!t) return h ? 2 * (x + y * p) : 4 * (x + y * p);
    if (!h) begin
      ba = (y / 8) * (p / 8) + x / 8;
      return (x % 8) * 4 + (y % 4) * 32 + (((x / 16) % 2) ^ ((y / 4) % 2)) * 128
           + (ba % 4) * 256 + ((y / 8) % 2) * 1024
           + (((x / 8) % 2) ^ ((y / 16) % 2)) * 2048 + (ba / 4) * 4096;
    end
    ba = (y / 16) * (p / 32) + x / 32;
    return (x % 8) * 2 + (y % 8) * 16 + ((x / 8) % 2) * 128
         + (ba % 4) * 256 + ((y / 8) % 2) * 1024
         + (((x / 16) % 2) ^ ((y / 16) % 2)) * 2048 + (ba / 4) * 4096;
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic xfer(int x, int y, int ox, int oy, int p, bit h, bit t, string req);
    int unsigned e;
    @(negedge clk);
    px = 12'(x); py = 12'(y); org_x = 12'(ox); org_y = 12'(oy);
    pitch = 12'(p); z16 = h; tiled = t; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = expect_addr(x + ox, y + oy, p, h, t);
    check(out_valid, {req, " R6 valid"}, 32'(out_valid), 1);
    check(addr == e, req, addr, e);
    check(addr[0] == 1'b0 && (h || addr[1] == 1'b0), "R9", addr, e);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 0);
    rst_n = 1'b1;

    for (int pi = 1; pi <= 3; pi++)
      for (int m = 0; m < 4; m++)
        for (int y = 0; y < 40; y++)
          for (int x = 0; x < 48; x++)
            xfer(x, y, 0, 0, 32 * pi, m[0], m[1],
                 m[1] ? (m[0] ? "R4" : "R3") : (m[0] ? "R2" : "R1"));

    for (int m = 0; m < 4; m++)
      for (int y = 0; y < 20; y++)
        for (int x = 0; x < 20; x++)
          xfer(x, y, 7, 13, 64, m[0], m[1], "R5");

    xfer(3, 5, 0, 0, 40, 1'b0, 1'b0, "R1");
    check(pitch_err == 1'b1, "R8 odd pitch", 32'(pitch_err), 1);
    xfer(3, 5, 0, 0, 33, 1'b1, 1'b0, "R2");
    check(pitch_err == 1'b1, "R8 odd pitch", 32'(pitch_err), 1);
    xfer(3, 5, 0, 0, 96, 1'b1, 1'b1, "R4");
    check(pitch_err == 1'b0, "R8 good pitch", 32'(pitch_err), 0);

    // R7 stall: first result held, second waits
    @(negedge clk);
    out_ready = 1'b0;
    px = 12'd9; py = 12'd21; org_x = '0; org_y = '0; pitch = 12'd64;
    z16 = 1'b0; tiled = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    px = 12'd30; py = 12'd2; z16 = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 ready", 32'(in_ready), 0);
      check(out_valid && addr == expect_addr(9, 21, 64, 1'b0, 1'b1), "R7 hold",
            addr, expect_addr(9, 21, 64, 1'b0, 1'b1));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && addr == expect_addr(30, 2, 64, 1'b1, 1'b1), "R7 next",
          addr, expect_addr(30, 2, 64, 1'b1, 1'b1));
    @(negedge clk);
    check(out_valid == 1'b0, "R6 drain", 32'(out_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule